// File: doc/BRIEF.md
# Slow Clock Calibration Counter

The block tells software how fast a slow, free-running clock really is. It does this by counting cycles of a fast reference clock while a chosen number of slow-clock periods go by. All of its logic runs in the reference domain. Each of the three candidate slow clocks passes through a two-flop synchronizer, and a rising-edge detector follows the selected one. The measurement window opens on the first detected slow edge after a run begins. It closes once the programmed number of further edges has been seen.

Configuration goes in through a single write strobe. That one write loads the start bit, the cycling bit, the source select, the window length and the timeout limit together. The status side gives a ready flag, a timeout flag and the counted result. A one-shot run measures once and then holds its outcome. In cycling mode the block re-arms after every outcome, with no software action, and keeps the result current. A timeout counter guards every run. It counts reference cycles from the start of the run, so a stopped or unselected slow clock ends the run with a timeout instead of hanging it.

Top module: `slow_clk_cal`

## Requirements
- R1: With a slow clock of period P reference cycles and a window length of N, a completed run reports exactly N*P on `countOut`.
- R2: A one-shot run begins only on a 0-to-1 change of the stored start bit. Writing start=1 while it is already 1 starts nothing, and `countOut` and the flags keep their values.
- R3: When a one-shot run completes, `readyFlag` goes to 1 and `timeoutFlag` stays 0. Both hold until the start bit is cleared or a new run begins.
- R4: Reset loads start=0, cycling=1, select=0, window=RST_WIN (2 by default) and a timeout limit of all ones. With the cycling bit set, the block measures by itself and re-arms after each outcome. `countOut` then follows later changes of select or window, and `readyFlag` stays 1.
- R5: Select value k in 0..2 measures `slowClk[k]`. Select value 3 connects no clock, so a run with it ends in a timeout.
- R6: A run times out when the timeout counter reaches `wrTimeout` before the window closes. The counter starts at 0 in the first armed cycle and adds 1 per reference cycle. A timeout sets `timeoutFlag`, clears `readyFlag` and forces `countOut` to 0.
- R7: `readyFlag` and `timeoutFlag` are never 1 together. If the window closes in the same cycle that the timeout limit is reached, completion wins. A limit below P always gives a timeout. A limit of 2P-1 or more always gives ready.
- R8: While both the start bit and the cycling bit are 0, both flags are 0 from the next cycle on.
- R9: A run started with a window length of 0 completes at once, with `readyFlag`=1, `countOut`=0 and `timeoutFlag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slowClk | input | NUM_SRC (3) | Candidate slow clocks, asynchronous to clk |
| cfgWrite | input | 1 | Loads all configuration fields below |
| wrStart | input | 1 | Start bit; a 0-to-1 change begins a one-shot run |
| wrCycle | input | 1 | Cycling-mode bit |
| wrSel | input | SEL_W (2) | Source select |
| wrWindow | input | WIN_W (12) | Window length in slow-clock cycles |
| wrTimeout | input | TO_W (24) | Timeout limit in reference cycles |
| readyFlag | output | 1 | Measurement completed |
| timeoutFlag | output | 1 | Measurement aborted by the timeout counter |
| countOut | output | CNT_W (24) | Reference cycles counted in the window |

## Verification
Two events can land in the same cycle: the close of the window and the timeout counter reaching its limit. The bench provokes this by running one-shot measurements of the 8-cycle clock over a one-cycle window while sweeping the timeout limit from 0 to 24. Because the slow clock's phase at start varies from run to run, some limits land exactly on the closing cycle. Each outcome is judged on three points: exactly one flag is set, a ready run reports 8, and limits below 8 or at 15 and above give the outcome fixed by R7 whatever the phase.

// File: rtl/slow_cal_pkg.sv
package slow_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS,
    ST_DONE
  } calState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic openWin;   // first slow edge seen: clear reference count, load edges
    logic countEn;   // window open: count reference cycles
    logic tickTo;    // run active: advance timeout counter
    logic clrTo;     // run begins: clear timeout counter
    logic latchRes;  // window closed: capture result
    logic zeroRes;   // timeout or empty window: result becomes zero
  } calStrobe_t;

endpackage

// File: rtl/slow_cal_path.sv
module slow_cal_path
  import slow_cal_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2,
  parameter int WIN_W   = 12,
  parameter int TO_W    = 24,
  parameter int CNT_W   = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] slowClk,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [WIN_W-1:0]   winLen,
  input  logic [TO_W-1:0]    toLimit,
  input  calStrobe_t         strobe,
  output logic               slowEdge,
  output logic               lastEdge,
  output logic               toHit,
  output logic [CNT_W-1:0]   countOut
);

  localparam logic [CNT_W-1:0] REF_MAX = '1;
  localparam logic [TO_W-1:0]  TO_MAX  = '1;

  logic [NUM_SRC-1:0] syncA, syncB;
  logic               selClk, prevClk;
  logic [WIN_W-1:0]   edgesLeft;
  logic [CNT_W-1:0]   refCnt;
  logic [TO_W-1:0]    toCnt;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
      end else begin
        syncA[g] <= slowClk[g];
        syncB[g] <= syncA[g];
      end
    end
  end

  always_comb begin
    selClk = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcSel == SEL_W'(i)) selClk = syncB[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= selClk;
  end

  assign slowEdge = selClk & ~prevClk;
  assign lastEdge = strobe.countEn && slowEdge && (edgesLeft <= WIN_W'(1));
  assign toHit    = strobe.tickTo && (toCnt == toLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgesLeft <= '0;
      refCnt    <= '0;
      toCnt     <= '0;
      countOut  <= '0;
    end else begin
      if (strobe.openWin) edgesLeft <= winLen;
      else if (strobe.countEn && slowEdge && edgesLeft != '0) edgesLeft <= edgesLeft - 1'b1;

      if (strobe.openWin) refCnt <= '0;
      else if (strobe.countEn && refCnt != REF_MAX) refCnt <= refCnt + 1'b1;

      if (strobe.clrTo) toCnt <= '0;
      else if (strobe.tickTo && toCnt != TO_MAX) toCnt <= toCnt + 1'b1;

      if (strobe.zeroRes)       countOut <= '0;
      else if (strobe.latchRes) countOut <= refCnt + 1'b1;
    end
  end

  // R1: a result is only captured on a detected slow-clock edge
  p_latch_on_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchRes |-> slowEdge);

endmodule

// File: rtl/slow_cal_ctrl.sv
module slow_cal_ctrl
  import slow_cal_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int WIN_W   = 12,
  parameter int TO_W    = 24,
  parameter int RST_WIN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic             wrStart,
  input  logic             wrCycle,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [WIN_W-1:0] wrWindow,
  input  logic [TO_W-1:0]  wrTimeout,
  input  logic             slowEdge,
  input  logic             lastEdge,
  input  logic             toHit,
  output logic [SEL_W-1:0] srcSel,
  output logic [WIN_W-1:0] winLen,
  output logic [TO_W-1:0]  toLimit,
  output calStrobe_t       strobe,
  output logic             readyFlag,
  output logic             timeoutFlag
);

  logic      startBit, startPrev, cycleBit, isCyc, nCyc;
  logic      nReady, nTimeout, launch, launchCyc, startRise;
  calState_e state, nState;

  assign startRise = startBit & ~startPrev;

  // configuration register (R4 reset values)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit  <= 1'b0;
      cycleBit  <= 1'b1;
      srcSel    <= '0;
      winLen    <= WIN_W'(RST_WIN);
      toLimit   <= '1;
      startPrev <= 1'b0;
    end else begin
      startPrev <= startBit;
      if (cfgWrite) begin
        startBit <= wrStart;
        cycleBit <= wrCycle;
        srcSel   <= wrSel;
        winLen   <= wrWindow;
        toLimit  <= wrTimeout;
      end
    end
  end

  always_comb begin
    nState    = state;
    nCyc      = isCyc;
    nReady    = readyFlag;
    nTimeout  = timeoutFlag;
    strobe    = '0;
    launch    = 1'b0;
    launchCyc = 1'b0;
    if (startRise) begin
      launch   = 1'b1;
      nReady   = 1'b0;
      nTimeout = 1'b0;
    end else if (state == ST_IDLE) begin
      if (cycleBit) begin
        launch    = 1'b1;
        launchCyc = 1'b1;
      end else if (!startBit) begin
        nReady   = 1'b0;
        nTimeout = 1'b0;
      end
    end else if (!startBit && !(isCyc && cycleBit)) begin
      nState   = ST_IDLE;
      nReady   = 1'b0;
      nTimeout = 1'b0;
    end else if (isCyc && !cycleBit) begin
      nState = ST_IDLE;
    end else begin
      case (state)
        ST_ARM: begin
          strobe.tickTo = 1'b1;
          if (toHit) begin
            strobe.zeroRes = 1'b1;
            nTimeout = 1'b1;
            nReady   = 1'b0;
            nState   = ST_DONE;
            launch   = isCyc;
            launchCyc = isCyc;
          end else if (slowEdge) begin
            strobe.openWin = 1'b1;
            nState = ST_MEAS;
          end
        end
        ST_MEAS: begin
          strobe.tickTo  = 1'b1;
          strobe.countEn = 1'b1;
          if (lastEdge) begin           // completion wins over timeout (R7)
            strobe.latchRes = 1'b1;
            nReady   = 1'b1;
            nTimeout = 1'b0;
            nState   = ST_DONE;
            launch   = isCyc;
            launchCyc = isCyc;
          end else if (toHit) begin
            strobe.zeroRes = 1'b1;
            nTimeout = 1'b1;
            nReady   = 1'b0;
            nState   = ST_DONE;
            launch   = isCyc;
            launchCyc = isCyc;
          end
        end
        default: ;
      endcase
    end
    if (launch) begin
      strobe.clrTo = 1'b1;
      nCyc = launchCyc;
      if (winLen == '0) begin
        strobe.zeroRes  = 1'b1;
        strobe.latchRes = 1'b0;
        nReady   = 1'b1;
        nTimeout = 1'b0;
        nState   = launchCyc ? ST_IDLE : ST_DONE;
      end else begin
        nState = ST_ARM;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      isCyc       <= 1'b0;
      readyFlag   <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      state       <= nState;
      isCyc       <= nCyc;
      readyFlag   <= nReady;
      timeoutFlag <= nTimeout;
    end
  end

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(readyFlag && timeoutFlag));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!startBit && !cycleBit) |=> (!readyFlag && !timeoutFlag));

  p_empty_window_r9: assert property (@(posedge clk) disable iff (!rstN)
    (startRise && winLen == '0) |=> (readyFlag && !timeoutFlag));

endmodule

// File: rtl/slow_clk_cal.sv
module slow_clk_cal
  import slow_cal_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2,
  parameter int WIN_W   = 12,
  parameter int TO_W    = 24,
  parameter int CNT_W   = 24,
  parameter int RST_WIN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] slowClk,
  input  logic               cfgWrite,
  input  logic               wrStart,
  input  logic               wrCycle,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [WIN_W-1:0]   wrWindow,
  input  logic [TO_W-1:0]    wrTimeout,
  output logic               readyFlag,
  output logic               timeoutFlag,
  output logic [CNT_W-1:0]   countOut
);

  calStrobe_t       strobe;
  logic [SEL_W-1:0] srcSel;
  logic [WIN_W-1:0] winLen;
  logic [TO_W-1:0]  toLimit;
  logic             slowEdge, lastEdge, toHit;

  slow_cal_ctrl #(.SEL_W(SEL_W), .WIN_W(WIN_W), .TO_W(TO_W), .RST_WIN(RST_WIN)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .wrStart(wrStart), .wrCycle(wrCycle),
    .wrSel(wrSel), .wrWindow(wrWindow), .wrTimeout(wrTimeout),
    .slowEdge(slowEdge), .lastEdge(lastEdge), .toHit(toHit),
    .srcSel(srcSel), .winLen(winLen), .toLimit(toLimit), .strobe(strobe),
    .readyFlag(readyFlag), .timeoutFlag(timeoutFlag)
  );

  slow_cal_path #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .WIN_W(WIN_W), .TO_W(TO_W),
                  .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .srcSel(srcSel), .winLen(winLen),
    .toLimit(toLimit), .strobe(strobe), .slowEdge(slowEdge), .lastEdge(lastEdge),
    .toHit(toHit), .countOut(countOut)
  );

  // R6: a timeout never leaves a stale count behind
  p_timeout_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (countOut == '0));

endmodule

// File: tb/slow_clk_cal_test.sv
`timescale 1ns/1ps
module slow_clk_cal_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  slowClk = 3'b000;
  logic [2:0]  halt = 3'b000;
  logic        cfgWrite = 1'b0, wrStart = 1'b0, wrCycle = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [11:0] wrWindow = '0;
  logic [23:0] wrTimeout = '0;
  logic        readyFlag, timeoutFlag;
  logic [23:0] countOut;

  int nCmp = 0, nBad = 0;
  bit finished = 1'b0;
  int ph [3] = '{0, 0, 0};
  localparam int HALF [3] = '{4, 7, 11};   // periods 8, 14, 22
  localparam int BIG = 24'hFFFFFF;
  // {select, window, expected count}
  localparam int VEC [6][3] = '{'{0,1,8}, '{0,5,40}, '{1,3,42}, '{2,4,88}, '{1,1,14}, '{2,2,44}};

  always #2.5 clk = ~clk;

  slow_clk_cal uut (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .cfgWrite(cfgWrite), .wrStart(wrStart),
    .wrCycle(wrCycle), .wrSel(wrSel), .wrWindow(wrWindow), .wrTimeout(wrTimeout),
    .readyFlag(readyFlag), .timeoutFlag(timeoutFlag), .countOut(countOut)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (halt[i]) slowClk[i] <= 1'b0;
      else if (ph[i] == HALF[i] - 1) begin
        ph[i] <= 0;
        slowClk[i] <= ~slowClk[i];
      end else ph[i] <= ph[i] + 1;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(bit st, bit cy, int sel, int win, int to);
    @(negedge clk);
    cfgWrite = 1'b1; wrStart = st; wrCycle = cy;
    wrSel = sel[1:0]; wrWindow = win[11:0]; wrTimeout = to[23:0];
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic waitDone(int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      if (readyFlag || timeoutFlag) break;
      @(negedge clk);
    end
  endtask

  task automatic oneShot(int sel, int win, int to);
    cfg(1'b0, 1'b0, sel, win, to);
    cfg(1'b1, 1'b0, sel, win, to);
    waitDone(4000);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int sawReady, sawTo;
    repeat (3) @(negedge clk);
    chk("R4 reset ready", readyFlag, 0);
    chk("R4 reset timeout", timeoutFlag, 0);
    chk("R4 reset count", countOut, 0);
    rstN = 1'b1;

    // R4: cycling is on after reset, select 0, window 2
    waitDone(400);
    chk("R4 default cycling ready", readyFlag, 1);
    chk("R4 default cycling count", countOut, 16);

    // R4: cycling re-arms and follows new settings
    cfg(1'b0, 1'b1, 1, 3, BIG);
    repeat (300) @(negedge clk);
    chk("R4 cycling sel1 count", countOut, 42);
    cfg(1'b0, 1'b1, 0, 3, BIG);
    repeat (300) @(negedge clk);
    chk("R4 cycling follows select", countOut, 24);
    chk("R4 cycling ready held", readyFlag, 1);

    // R8: both bits cleared drops the flags
    cfg(1'b0, 1'b0, 0, 3, BIG);
    repeat (2) @(negedge clk);
    chk("R8 stop clears ready", readyFlag, 0);
    chk("R8 stop clears timeout", timeoutFlag, 0);

    // R1, R3, R5: one-shot table
    foreach (VEC[k]) begin
      oneShot(VEC[k][0], VEC[k][1], BIG);
      chk($sformatf("R3 vec%0d ready", k), readyFlag, 1);
      chk($sformatf("R3 vec%0d timeout", k), timeoutFlag, 0);
      chk($sformatf("R1 R5 vec%0d count", k), countOut, VEC[k][2]);
    end

    // R2: start held high does not retrigger (last vector gave 44)
    cfg(1'b1, 1'b0, 0, 1, BIG);
    repeat (100) @(negedge clk);
    chk("R2 no retrigger count", countOut, 44);
    chk("R2 no retrigger ready", readyFlag, 1);
    // R3: ready holds until start cleared; R8 clear
    cfg(1'b0, 1'b0, 0, 1, BIG);
    repeat (2) @(negedge clk);
    chk("R8 one-shot clear", readyFlag, 0);

    // R9: zero window
    oneShot(0, 0, BIG);
    chk("R9 zero ready", readyFlag, 1);
    chk("R9 zero count", countOut, 0);
    chk("R9 zero timeout", timeoutFlag, 0);

    // R6: stopped clock times out near the limit
    halt[2] = 1'b1;
    cfg(1'b0, 1'b0, 2, 2, 40);
    cfg(1'b1, 1'b0, 2, 2, 40);
    repeat (30) @(negedge clk);
    chk("R6 no early timeout", timeoutFlag, 0);
    repeat (20) @(negedge clk);
    chk("R6 timeout flag", timeoutFlag, 1);
    chk("R6 timeout ready", readyFlag, 0);
    chk("R6 timeout count", countOut, 0);
    halt[2] = 1'b0;

    // R5: select 3 has no clock
    oneShot(3, 1, 60);
    chk("R5 sel3 timeout", timeoutFlag, 1);
    chk("R5 sel3 ready", readyFlag, 0);

    // R7: sweep the limit across the closing cycle of an 8-cycle window
    sawReady = 0; sawTo = 0;
    for (int lim = 0; lim <= 24; lim++) begin
      oneShot(0, 1, lim);
      chk($sformatf("R7 lim%0d one flag", lim), int'(readyFlag) + int'(timeoutFlag), 1);
      if (readyFlag) begin
        sawReady++;
        chk($sformatf("R7 lim%0d count", lim), countOut, 8);
      end else sawTo++;
      if (lim < 8)   chk($sformatf("R7 lim%0d must time out", lim), timeoutFlag, 1);
      if (lim >= 15) chk($sformatf("R7 lim%0d must be ready", lim), readyFlag, 1);
    end
    chk("R7 both outcomes seen", (sawReady > 0) && (sawTo > 0), 1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule